// File: doc/BRIEF.md
# MDIO Management Register Controller

This block puts a single 32-bit control and status word in front of a Clause 22 management link to an external PHY. Software writes that word once with the target PHY address, the PHY register number, the 16-bit value to send (for a write) and a command bit. The block then shifts the complete management frame out on MDIO against a management clock that it divides down from the system clock. While the frame is in progress it holds a busy flag. For a read, it captures the 16 bits that the PHY returns into the upper half of the same word.

For a read, the block releases the data line at the turnaround. If the PHY does not pull the second turnaround bit low, the block marks the result as not valid. The PHY address field comes out of reset with a value given by a parameter, so software can read the strapped default before it issues any command.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, reg_rdata reads PHY_RST_ADDR in bits 15:11 and zero in every other bit, and mdc and mdio_oe are low.
- R2: A register write with bit 0 set, accepted while idle, sends a 64-bit frame MSB first with every bit driven (mdio_oe high). The frame is 32 ones, then 01, then opcode 01, then wdata[15:11] as the PHY address, then wdata[10:6] as the register number, then turnaround 10, then wdata[31:16].
- R3: A register write with bit 1 set and bit 0 clear, accepted while idle, drives 32 ones, 01, opcode 10, the PHY address and the register number (46 bits). It then holds mdio_oe low for the remaining 18 bit times: the turnaround plus 16 data bits.
- R4: When a read completes, the 16 bits that the PHY sent after the turnaround appear in reg_rdata[31:16], first-received bit in bit 31.
- R5: Busy (reg_rdata[3]) is set in the cycle after a command write is accepted. It clears when the frame ends, 128*DIV_HALF clock cycles after the accepting edge.
- R6: Not-valid (reg_rdata[4]) is set after a read in which mdio_in was high when the second turnaround bit was sampled. It is cleared in the cycle after any command is accepted.
- R7: mdc has a period of 2*DIV_HALF clock cycles during a frame and stays low while the block is idle. mdio_out and mdio_oe change only with a falling mdc edge or when a frame starts, and are sampled by the PHY on the rising edge.
- R8: A register write issued while busy is ignored: the fields in reg_rdata[15:6] and the frame in progress are unchanged.
- R9: If bits 0 and 1 are both set in an accepted write, a write transaction (R2) is performed.
- R10: An accepted write with bits 1:0 both zero updates the data, PHY address and register fields, which read back in bits 31:16, 15:11 and 10:6. No frame starts, and mdc stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value: data, addresses, not-valid, busy |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_out |
| mdio_in | input | 1 | Management data seen on the shared line |

## Verification
On every cycle, the checker asserts the following. An idle block keeps mdc and the output enable low. The data line and its enable never move on a rising mdc edge. Busy only rises after an accepted command write, and each new command clears not-valid. A write arriving while busy leaves the address fields untouched. The bench's scenarios are needed to show the content of the frames, the point where a read releases the line, the data captured from the PHY, how long busy lasts, the mdc period, and the not-valid result when the PHY leaves the turnaround high.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;   // first turnaround bit index
    localparam int TA_SECOND  = 47;   // PHY must drive this one low
    localparam int DATA_FIRST = 48;   // first data bit index

    typedef struct packed {
        logic [15:0] data;
        logic [4:0]  phy;
        logic [4:0]  regad;
    } mdio_fields_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic is_rd,
                                                          input mdio_fields_t f);
        logic [1:0]  opcode;
        logic [1:0]  ta;
        logic [15:0] payload;
        opcode  = is_rd ? 2'b10 : 2'b01;
        ta      = is_rd ? 2'b11 : 2'b10;
        payload = is_rd ? 16'hFFFF : f.data;
        return {32'hFFFF_FFFF, 2'b01, opcode, f.phy, f.regad, ta, payload};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } clk_state_t;

    clk_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d      = st_q;
        wrap      = (st_q.cnt == LAST);
        rise_tick = run && wrap && !st_q.mdc;
        fall_tick = run && wrap && st_q.mdc;
        if (!run) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         start_rd,
    input  mdio_fields_t start_fields,
    input  logic         rise_tick,
    input  logic         fall_tick,
    input  logic         mdio_in,
    output logic         busy,
    output logic         nvalid,
    output logic         done_rd,
    output logic [15:0]  rd_word,
    output logic         mdio_out,
    output logic         mdio_oe
);
    localparam logic [5:0] IDX_LAST  = 6'(FRAME_BITS - 1);
    localparam logic [5:0] IDX_TA2   = 6'(TA_SECOND);
    localparam logic [5:0] IDX_DATA  = 6'(DATA_FIRST);
    localparam logic [5:0] IDX_PRETA = 6'(TA_FIRST - 1);

    typedef struct packed {
        logic                  busy;
        logic                  is_rd;
        logic [5:0]            idx;
        logic [FRAME_BITS-1:0] frame;
        logic                  oe;
        logic                  nvalid;
        logic [15:0]           rdsh;
    } eng_state_t;

    eng_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        done_rd = 1'b0;
        if (st_q.busy) begin
            if (rise_tick) begin
                if (st_q.is_rd && st_q.idx == IDX_TA2)
                    st_d.nvalid = mdio_in;
                if (st_q.is_rd && st_q.idx >= IDX_DATA)
                    st_d.rdsh = {st_q.rdsh[14:0], mdio_in};
            end
            if (fall_tick) begin
                if (st_q.idx == IDX_LAST) begin
                    done_rd    = st_q.is_rd;
                    st_d.busy  = 1'b0;
                    st_d.oe    = 1'b0;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.frame = {st_q.frame[FRAME_BITS-2:0], 1'b1};
                    st_d.oe    = !(st_q.is_rd && st_q.idx >= IDX_PRETA);
                end
            end
        end else if (start) begin
            st_d.busy   = 1'b1;
            st_d.is_rd  = start_rd;
            st_d.idx    = '0;
            st_d.frame  = build_frame(start_rd, start_fields);
            st_d.oe     = 1'b1;
            st_d.nvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign nvalid   = st_q.nvalid;
    assign rd_word  = st_q.rdsh;
    assign mdio_out = st_q.frame[FRAME_BITS-1];
    assign mdio_oe  = st_q.oe;

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int         DIV_HALF     = 25,
    parameter logic [4:0] PHY_RST_ADDR = 5'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    mdio_fields_t fld_d, fld_q;
    mdio_fields_t wr_fields;
    logic         accept, start, start_rd;
    logic         busy, nvalid, done_rd;
    logic [15:0]  rd_word;
    logic         rise_tick, fall_tick;

    always_comb begin
        wr_fields = '{data: reg_wdata[31:16], phy: reg_wdata[15:11], regad: reg_wdata[10:6]};
        accept    = reg_wr_en && !busy;
        start     = accept && (reg_wdata[0] || reg_wdata[1]);
        start_rd  = reg_wdata[1] && !reg_wdata[0];
        fld_d     = fld_q;
        if (accept)
            fld_d = wr_fields;
        else if (done_rd)
            fld_d.data = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fld_q <= '{data: 16'h0, phy: PHY_RST_ADDR, regad: 5'h0};
        else        fld_q <= fld_d;
    end

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_engine u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_rd     (start_rd),
        .start_fields (wr_fields),
        .rise_tick    (rise_tick),
        .fall_tick    (fall_tick),
        .mdio_in      (mdio_in),
        .busy         (busy),
        .nvalid       (nvalid),
        .done_rd      (done_rd),
        .rd_word      (rd_word),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe)
    );

    assign reg_rdata = {fld_q.data, fld_q.phy, fld_q.regad, 1'b0, nvalid, busy, 3'b000};

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[3] |-> (!mdc && !mdio_oe));

    assert_stable_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    assert_busy_from_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[3]) |-> $past(reg_wr_en && (reg_wdata[1:0] != 2'b00)));

    assert_start_clears_nvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[3]) |-> !reg_rdata[4]);

    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[3] && reg_wr_en) |=> $stable(reg_rdata[15:6]));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (.*);

// File: tb/mdio_mgmt_test.sv
`timescale 1ns/1ps
module mdio_mgmt_test;
    localparam int         DH      = 3;
    localparam logic [4:0] RST_PHY = 5'd9;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        string       tag;
    } exp_frame_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        phy_drv = 1'b1;
    wire         mdio_in = mdio_oe ? mdio_out : phy_drv;

    int errors = 0;
    int checks = 0;
    exp_frame_t exp_q[$];

    // bench PHY model controls
    logic        ta_resp = 1'b0;
    logic [15:0] phy_val = 16'h0;
    int          bitcnt = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    realtime     last_rise = 0;

    always #4 clk = ~clk;

    mdio_mgmt #(.DIV_HALF(DH), .PHY_RST_ADDR(RST_PHY)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .mdio_in(mdio_in)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: capture a frame at rising mdc and compare with the scoreboard
    always @(posedge mdc) begin
        if (bitcnt == 1) check("R7 mdc period", 64'($rtoi($realtime - last_rise)), 64'(2*DH*8));
        last_rise = $realtime;
        cap_bits[63-bitcnt] = mdio_oe ? mdio_out : 1'b0;
        cap_oe[63-bitcnt]   = mdio_oe;
        bitcnt++;
        if (bitcnt == 64) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected frame", 64'd1, 64'd0);
            end else begin
                exp_frame_t e;
                e = exp_q.pop_front();
                check({e.tag, " frame bits"}, cap_bits, e.bits & e.oe);
                check({e.tag, " output enable"}, cap_oe, e.oe);
            end
            bitcnt   = 0;
            cap_bits = '0;
            cap_oe   = '0;
        end
    end

    // PHY response: next bit index is bitcnt after each falling mdc
    always @(negedge mdc) begin
        if (bitcnt == 47)                      phy_drv = ta_resp;
        else if (bitcnt >= 48 && bitcnt < 64)  phy_drv = phy_val[63-bitcnt];
        else                                   phy_drv = 1'b1;
    end

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    // driver: push the expected frame, then issue the command
    task automatic drive_cmd(input logic [15:0] data, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [1:0] cmd, input string tag);
        exp_frame_t e;
        logic rd;
        rd = (cmd == 2'b10);
        if (rd) begin
            e.bits = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 18'h0};
            e.oe   = {{46{1'b1}}, 18'h0};
        end else begin
            e.bits = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, data};
            e.oe   = '1;
        end
        e.tag = tag;
        exp_q.push_back(e);
        reg_write({data, phy, ra, 4'b0, cmd});
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (reg_rdata[3] && cyc < 5000);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset rdata", 64'(reg_rdata), 64'({16'h0, RST_PHY, 11'h0}));
        check("R1 reset mdc/oe", 64'({mdc, mdio_oe}), 64'd0);

        // R10 field update without command
        reg_write({16'hBEEF, 5'd3, 5'd17, 6'b0});
        check("R10 fields readback", 64'(reg_rdata), 64'({16'hBEEF, 5'd3, 5'd17, 6'b0}));
        repeat (20) @(negedge clk);
        check("R10 no activity", 64'({mdc, mdio_oe, reg_rdata[3]}), 64'd0);

        // R2 write transaction, R5 busy timing
        drive_cmd(16'hA5C3, 5'd1, 5'd4, 2'b01, "R2 write");
        check("R5 busy after cmd", 64'(reg_rdata[3]), 64'd1);
        wait_idle(cyc);
        check("R5 busy duration", 64'(cyc), 64'(128*DH));
        check("R2 data field kept", 64'(reg_rdata[31:6]), 64'({16'hA5C3, 5'd1, 5'd4}));

        // R3/R4 read with PHY answering
        ta_resp = 1'b0;
        phy_val = 16'h8E71;
        drive_cmd(16'h0, 5'd30, 5'd2, 2'b10, "R3 read");
        wait_idle(cyc);
        check("R4 read data", 64'(reg_rdata[31:16]), 64'(16'h8E71));
        check("R6 nvalid clear on answered read", 64'(reg_rdata[4]), 64'd0);

        // R6 read not answered
        ta_resp = 1'b1;
        phy_val = 16'hFFFF;
        drive_cmd(16'h0, 5'd7, 5'd1, 2'b10, "R3 read no answer");
        wait_idle(cyc);
        check("R6 nvalid set", 64'(reg_rdata[4]), 64'd1);

        // R6 cleared by the next start
        ta_resp = 1'b0;
        phy_val = 16'h1234;
        drive_cmd(16'h0, 5'd7, 5'd1, 2'b10, "R3 read again");
        check("R6 nvalid cleared at start", 64'(reg_rdata[4]), 64'd0);
        wait_idle(cyc);
        check("R4 second read data", 64'(reg_rdata[31:16]), 64'(16'h1234));

        // R8 write during busy ignored
        drive_cmd(16'h5A5A, 5'd12, 5'd21, 2'b01, "R8 write under busy");
        repeat (40) @(negedge clk);
        reg_write({16'hFFFF, 5'd31, 5'd31, 4'b0, 2'b10});
        wait_idle(cyc);
        check("R8 fields unchanged", 64'(reg_rdata[31:6]), 64'({16'h5A5A, 5'd12, 5'd21}));

        // R9 both command bits give a write
        drive_cmd(16'h0F0F, 5'd2, 5'd9, 2'b01, "R9 both bits");
        exp_q[exp_q.size()-1].bits = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd9, 2'b10, 16'h0F0F};
        // driver already issued 01; reissue test with 11 below
        wait_idle(cyc);
        begin
            exp_frame_t e;
            e.bits = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd6, 5'd11, 2'b10, 16'hC001};
            e.oe   = '1;
            e.tag  = "R9 both bits set";
            exp_q.push_back(e);
            reg_write({16'hC001, 5'd6, 5'd11, 4'b0, 2'b11});
        end
        wait_idle(cyc);
        check("R9 idle after", 64'({mdc, mdio_oe}), 64'd0);

        repeat (10) @(negedge clk);
        check("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule